// File: doc/BRIEF.md
# Multiphase Phase Shedding Controller

This block decides how many interleaved boost phases run at light load. A load estimator supplies a target phase count. The block clamps that count to the configured minimum and to the number of phases, and it drives an active-phase mask. Phases are removed from the highest index down. While any phase is shed, the block asks the analog side to compare each channel against a reduced current limit, two thirds of the normal value.

If any running phase crosses the reduced limit, the block brings back every phase in the next cycle. It then refuses to shed again for a fixed hold time. Each time phases are added, it raises a blanking window that masks the per-channel overcurrent shutdown.

Diode emulation is allowed only when the tri-state enable input is high and exactly two phases run. The two phases may come from shedding or from the minimum setting. In that mode, a phase that reports zero inductor current gets a tri-state request for its PWM output. The request lasts until the next switching period starts.

Top module: `phase_shed_ctrl`

## Requirements
- R1: After reset, all phases are enabled and `lim_reduce_o`, `ocp_blank_o` and `pwm_tri_o` are all low.
- R2: When no hold is running, the active count takes the clamped target one clock after the target is presented. Bit i of `phase_en_o` is set exactly when i is below the active count, so phases leave from the highest index down.
- R3: `lim_reduce_o` is high exactly when fewer than `N_PHASES` phases are enabled.
- R4: If `lim_reduce_o` is high and `near_lim_i` is set on a bit whose phase is enabled, all phases are enabled after the next clock edge. `near_lim_i` bits of disabled phases have no effect.
- R5: After such a restore, the active count stays at `N_PHASES` for `HOLD_CYC` further clock edges. It then follows the clamped target again.
- R6: Whenever the active count rises, whether by a restore or by a target increase, `ocp_blank_o` is high for `BLANK_CYC` cycles, starting one clock later. A new rise reloads the window.
- R7: `pwm_tri_o` is all zero whenever `tri_en_i` is low or the active count differs from two. This gating acts without waiting for a clock.
- R8: In diode emulation, `zero_cur_i` on an enabled phase sets that phase's `pwm_tri_o` bit after the next edge. The bit then stays set after `zero_cur_i` falls. `zero_cur_i` on a disabled phase has no effect.
- R9: A high `period_start_i` clears every tri-state request after the next edge. It wins over a simultaneous `zero_cur_i`.
- R10: The clamped target is max(`min_cnt_i`, 1), limited to `N_PHASES`, when the target is below that value. It is `N_PHASES` when the target exceeds it. Otherwise it is the target itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| target_cnt_i | input | CW | Phase count requested by the load estimator |
| min_cnt_i | input | CW | Configured minimum phase count |
| near_lim_i | input | N_PHASES | Per-phase flag: current above the reduced limit |
| zero_cur_i | input | N_PHASES | Per-phase flag: inductor current at zero |
| tri_en_i | input | 1 | Permits diode emulation through PWM tri-state |
| period_start_i | input | 1 | Strobe at the start of each switching period |
| phase_en_o | output | N_PHASES | Active-phase mask |
| lim_reduce_o | output | 1 | Selects the reduced current-limit reference |
| ocp_blank_o | output | 1 | Masks per-channel overcurrent shutdown |
| pwm_tri_o | output | N_PHASES | Per-phase PWM tri-state request |

## Verification
The bench builds the block with four phases, a hold of 12 cycles and a blanking window of 5 cycles. With these values, the whole restore–hold–reshed sequence and the end of the blanking window fall inside a few dozen cycles. This lets the directed part check the exact cycle on which the hold and the window each end. Four phases also leave room for both sides of the two-phase diode-emulation condition, and for near-limit flags on phases that are shed. A randomized stretch then mixes target changes, minimum changes, near-limit events and period strobes against a behavioural model.

// File: rtl/phase_shed_pkg.sv
package phase_shed_pkg;

  // clamp a requested count to [max(min,1), n]
  function automatic int unsigned clamp_target(int unsigned tgt, int unsigned min_c,
                                               int unsigned n);
    int unsigned lo;
    lo = (min_c < 1) ? 1 : min_c;
    if (lo > n) lo = n;
    if (tgt < lo) return lo;
    if (tgt > n) return n;
    return tgt;
  endfunction

endpackage

// File: rtl/phase_shed_timer.sv
module phase_shed_timer #(
  parameter int unsigned LEN = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned W = $clog2(LEN + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= W'(LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/phase_shed_count.sv
module phase_shed_count #(
  parameter int unsigned N_PHASES  = 4,
  parameter int unsigned HOLD_CYC  = 1500,
  parameter int unsigned BLANK_CYC = 200,
  localparam int unsigned CW = $clog2(N_PHASES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CW-1:0]       tgt_i,
  input  logic [N_PHASES-1:0] near_i,
  output logic [CW-1:0]       cnt_o,
  output logic [N_PHASES-1:0] en_o,
  output logic                reduce_o,
  output logic                blank_o
);
  logic [CW-1:0] cnt_q;
  logic          hold_busy;
  logic          restore;
  logic          add;

  for (genvar i = 0; i < N_PHASES; i++) begin : g_mask
    assign en_o[i] = (cnt_q > CW'(i));
  end

  assign reduce_o = (cnt_q != CW'(N_PHASES));
  assign restore  = reduce_o && |(near_i & en_o);
  assign add      = restore || (!hold_busy && (tgt_i > cnt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= CW'(N_PHASES);
    else if (restore)    cnt_q <= CW'(N_PHASES);
    else if (!hold_busy) cnt_q <= tgt_i;
  end

  phase_shed_timer #(.LEN(HOLD_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (restore),
    .busy_o (hold_busy)
  );

  phase_shed_timer #(.LEN(BLANK_CYC)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (add),
    .busy_o (blank_o)
  );

  assign cnt_o = cnt_q;
endmodule

// File: rtl/phase_shed_de.sv
module phase_shed_de #(
  parameter int unsigned N_PHASES = 4,
  localparam int unsigned CW = $clog2(N_PHASES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CW-1:0]       cnt_i,
  input  logic [N_PHASES-1:0] en_i,
  input  logic                tri_en_i,
  input  logic                period_start_i,
  input  logic [N_PHASES-1:0] zero_i,
  output logic [N_PHASES-1:0] tri_o
);
  logic de_ok;
  logic [N_PHASES-1:0] tri_q;

  assign de_ok = tri_en_i && (cnt_i == CW'(2));

  for (genvar i = 0; i < N_PHASES; i++) begin : g_ph
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             tri_q[i] <= 1'b0;
      else if (period_start_i) tri_q[i] <= 1'b0;
      else                     tri_q[i] <= de_ok & (tri_q[i] | (zero_i[i] & en_i[i]));
    end
    assign tri_o[i] = tri_q[i] & en_i[i] & de_ok;
  end
endmodule

// File: rtl/phase_shed_ctrl.sv
module phase_shed_ctrl #(
  parameter int unsigned N_PHASES  = 4,
  parameter int unsigned HOLD_CYC  = 1500,
  parameter int unsigned BLANK_CYC = 200,
  localparam int unsigned CW = $clog2(N_PHASES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CW-1:0]       target_cnt_i,
  input  logic [CW-1:0]       min_cnt_i,
  input  logic [N_PHASES-1:0] near_lim_i,
  input  logic [N_PHASES-1:0] zero_cur_i,
  input  logic                tri_en_i,
  input  logic                period_start_i,
  output logic [N_PHASES-1:0] phase_en_o,
  output logic                lim_reduce_o,
  output logic                ocp_blank_o,
  output logic [N_PHASES-1:0] pwm_tri_o
);
  logic [CW-1:0] tgt_clamped;
  logic [CW-1:0] act_cnt;

  assign tgt_clamped = CW'(phase_shed_pkg::clamp_target(32'(target_cnt_i),
                                                        32'(min_cnt_i), N_PHASES));

  phase_shed_count #(
    .N_PHASES  (N_PHASES),
    .HOLD_CYC  (HOLD_CYC),
    .BLANK_CYC (BLANK_CYC)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tgt_i    (tgt_clamped),
    .near_i   (near_lim_i),
    .cnt_o    (act_cnt),
    .en_o     (phase_en_o),
    .reduce_o (lim_reduce_o),
    .blank_o  (ocp_blank_o)
  );

  phase_shed_de #(.N_PHASES(N_PHASES)) u_de (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cnt_i          (act_cnt),
    .en_i           (phase_en_o),
    .tri_en_i       (tri_en_i),
    .period_start_i (period_start_i),
    .zero_i         (zero_cur_i),
    .tri_o          (pwm_tri_o)
  );
endmodule

// File: rtl/phase_shed_ctrl_chk.sv
module phase_shed_ctrl_chk #(
  parameter int unsigned N_PHASES = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_PHASES-1:0] near_lim_i,
  input logic                tri_en_i,
  input logic                period_start_i,
  input logic [N_PHASES-1:0] phase_en_o,
  input logic                lim_reduce_o,
  input logic                ocp_blank_o,
  input logic [N_PHASES-1:0] pwm_tri_o
);
  // R2
  mask_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_en_o + N_PHASES'(1)) & phase_en_o) == '0);

  // R4
  restore_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_reduce_o && |(near_lim_i & phase_en_o)) |=> (&phase_en_o));

  // R5
  restore_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_reduce_o && |(near_lim_i & phase_en_o)) |=> ##1 (&phase_en_o));

  // R6
  add_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_en_o & ~$past(phase_en_o)) != '0) |-> ocp_blank_o);

  // R7
  de_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pwm_tri_o) |-> (tri_en_i && $countones(phase_en_o) == 2));

  // R8
  tri_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_tri_o & ~phase_en_o) == '0);

  // R9
  period_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i |=> (pwm_tri_o == '0));
endmodule

bind phase_shed_ctrl phase_shed_ctrl_chk #(.N_PHASES(N_PHASES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .near_lim_i     (near_lim_i),
  .tri_en_i       (tri_en_i),
  .period_start_i (period_start_i),
  .phase_en_o     (phase_en_o),
  .lim_reduce_o   (lim_reduce_o),
  .ocp_blank_o    (ocp_blank_o),
  .pwm_tri_o      (pwm_tri_o)
);

// File: tb/phase_shed_ctrl_bench.sv
module phase_shed_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int HOLD = 12;
  localparam int BLANK = 5;
  localparam int CW = $clog2(N + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic [CW-1:0] target = CW'(N);
  logic [CW-1:0] min_c = CW'(1);
  logic [N-1:0] near = '0;
  logic [N-1:0] zero = '0;
  logic tri_en = 0;
  logic pstart = 0;
  logic [N-1:0] phase_en;
  logic lim_red;
  logic blank;
  logic [N-1:0] pwm_tri;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  phase_shed_ctrl #(.N_PHASES(N), .HOLD_CYC(HOLD), .BLANK_CYC(BLANK)) u_phase_shed_ctrl (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .target_cnt_i   (target),
    .min_cnt_i      (min_c),
    .near_lim_i     (near),
    .zero_cur_i     (zero),
    .tri_en_i       (tri_en),
    .period_start_i (pstart),
    .phase_en_o     (phase_en),
    .lim_reduce_o   (lim_red),
    .ocp_blank_o    (blank),
    .pwm_tri_o      (pwm_tri)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt, m_hold, m_blank;
  bit m_tri[N];

  function automatic int clamp(int t, int m);
    int lo;
    lo = (m < 1) ? 1 : m;
    if (lo > N) lo = N;
    if (t < lo) return lo;
    if (t > N) return N;
    return t;
  endfunction

  function automatic int mask_of(int c);
    return (1 << c) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = N; m_hold = 0; m_blank = 0;
      foreach (m_tri[i]) m_tri[i] = 0;
    end else begin
      int t, en;
      bit restore, add, de_ok;
      t = clamp(int'(target), int'(min_c));
      en = mask_of(m_cnt);
      de_ok = tri_en && (m_cnt == 2);
      restore = (m_cnt < N) && ((int'(near) & en) != 0);
      add = restore || (m_hold == 0 && t > m_cnt);
      foreach (m_tri[i])
        if (pstart) m_tri[i] = 0;
        else m_tri[i] = de_ok && (m_tri[i] || (zero[i] && en[i]));
      if (add) m_blank = BLANK; else if (m_blank > 0) m_blank--;
      if (restore) begin m_cnt = N; m_hold = HOLD; end
      else begin
        if (m_hold == 0) m_cnt = t;
        else m_hold--;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int en, tri_exp;
      en = mask_of(m_cnt);
      tri_exp = 0;
      if (tri_en && m_cnt == 2)
        foreach (m_tri[i]) if (m_tri[i] && en[i]) tri_exp |= (1 << i);
      chk("R2 model phase_en", int'(phase_en), en);
      chk("R3 model lim_reduce", int'(lim_red), int'(m_cnt < N));
      chk("R6 model ocp_blank", int'(blank), int'(m_blank > 0));
      chk("R7 model pwm_tri", int'(pwm_tri), tri_exp);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    #1;
    // R1
    chk("R1 phase_en", int'(phase_en), 'hF);
    chk("R1 lim_reduce", int'(lim_red), 0);
    chk("R1 blank", int'(blank), 0);
    chk("R1 tri", int'(pwm_tri), 0);

    target = 2; tick();
    chk("R2 shed to 2", int'(phase_en), 'h3);
    chk("R3 reduced limit", int'(lim_red), 1);
    target = 1; tick();
    chk("R2 shed to 1", int'(phase_en), 'h1);
    target = 0; tick();
    chk("R10 floor one", int'(phase_en), 'h1);
    min_c = 2; target = 1; tick();
    chk("R10 min clamp", int'(phase_en), 'h3);
    chk("R6 blank on rise", int'(blank), 1);
    min_c = 1; target = 7; tick();
    chk("R10 ceiling", int'(phase_en), 'hF);
    chk("R3 full limit", int'(lim_red), 0);
    target = 2; tick();
    chk("R2 back to 2", int'(phase_en), 'h3);

    tri_en = 1; zero = 4'b0001; tick();
    chk("R8 tri set", int'(pwm_tri), 'h1);
    zero = 4'b0000; tick();
    chk("R8 tri held", int'(pwm_tri), 'h1);
    zero = 4'b1000; tick();
    chk("R8 disabled zero ignored", int'(pwm_tri), 'h1);
    pstart = 1; zero = 4'b0010; tick();
    chk("R9 period clear", int'(pwm_tri), 0);
    pstart = 0; zero = 4'b0010; tick();
    chk("R8 phase1 set", int'(pwm_tri), 'h2);
    zero = 0; tri_en = 0; #1;
    chk("R7 tri_en gate", int'(pwm_tri), 0);

    near = 4'b1000; tick();
    chk("R4 disabled near ignored", int'(phase_en), 'h3);
    near = 4'b0010; tick();
    near = 0;
    chk("R4 restore all", int'(phase_en), 'hF);
    chk("R6 blank on restore", int'(blank), 1);
    for (int k = 1; k <= HOLD; k++) begin
      tick();
      chk("R5 hold full", int'(phase_en), 'hF);
      chk("R6 blank window", int'(blank), int'(k < BLANK));
    end
    tick();
    chk("R5 reshed after hold", int'(phase_en), 'h3);

    target = 3; tick();
    chk("R2 rise to 3", int'(phase_en), 'h7);
    chk("R6 blank on target rise", int'(blank), 1);
    tri_en = 1; zero = 4'b0001; tick();
    chk("R7 three phases no tri", int'(pwm_tri), 0);
    zero = 0;

    for (int n = 0; n < 600; n++) begin
      target = CW'($urandom_range(0, 5));
      if ($urandom_range(0, 9) == 0) min_c = CW'($urandom_range(0, 3));
      near = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
      zero = N'($urandom);
      tri_en = ($urandom_range(0, 3) != 0);
      pstart = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) != 0) target = 2;
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule